// File: doc/BRIEF.md
# Serial-Wire Debug Host Transaction Engine

This block is the host side of a two-wire serial debug link. A client hands it one request at a time: which port to address (debug or access), the direction, a two-bit register address and, for writes, a 32-bit word. The engine turns that into a complete bit-serial transaction. It generates the serial clock, drives the data line through an output enable, and releases the line whenever the target is supposed to talk. When the transaction ends it returns the acknowledge code, the read word and a parity flag, along with a one-cycle completion strobe.

The serial clock is a divided copy of the system clock. It toggles only while a transaction is in flight and rests low otherwise. Every serial bit fills one full clock period. The engine changes the data it drives while the clock is low and samples incoming bits on the low-to-high transition. Retry on a wait response, overrun recovery and line reset are left to the client.

Top module: `swd_host_engine`

## Requirements
- R1: The 8-bit request header is driven LSB first. Bit 0 is 1. Bit 1 is the port select (1 = access port). Bit 2 is the direction (1 = read). Bits 3 and 4 are `req_addr_i[0]` and `req_addr_i[1]`. Bit 6 is 0 and bit 7 is 1.
- R2: Header bit 5 is a parity bit that makes bits 1 to 5 hold an even number of ones.
- R3: `swdio_oe_o` is 0 during the turnaround cycle after the header, the three acknowledge cycles, and every turnaround cycle after the acknowledge. On a read it is also 0 during the data and parity bits. It is 1 during the header and the write data and parity bits, and whenever the engine is idle.
- R4: The acknowledge is sampled LSB first over three bits and reported on `ack_o`. The value 3'b001 means OK.
- R5: On an OK read, 32 bits are sampled LSB first and presented on `rdata_o` at completion.
- R6: On an OK read, `perr_o` is 1 exactly when the received parity bit differs from the XOR of the 32 received bits. Writes and faulted transfers report 0.
- R7: On an OK write, one turnaround cycle follows the acknowledge. The engine then drives the 32 data bits LSB first, followed by their XOR as a parity bit.
- R8: A non-OK acknowledge skips the data phase. One turnaround cycle follows and the engine completes after 13 serial clock periods in total, leaving `rdata_o` unchanged. OK transfers take 46 periods.
- R9: Each serial clock half period lasts `clk_div_i`+1 system clock cycles. The driven data and its enable do not change while the serial clock is high.
- R10: `busy_o` rises the cycle after a request is accepted and falls in the same cycle that `done_o` pulses for exactly one cycle. Requests presented while busy are ignored.
- R11: After reset `busy_o`, `done_o` and `swclk_o` are 0 and `swdio_oe_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div_i | input | DIV_W | Serial half period minus one, in system cycles; hold stable while busy |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_ap_i | input | 1 | 1 selects access port, 0 debug port |
| req_read_i | input | 1 | 1 read, 0 write |
| req_addr_i | input | 2 | Register address bits [3:2] |
| req_wdata_i | input | DATA_W | Write word |
| busy_o | output | 1 | Transaction in flight |
| done_o | output | 1 | One-cycle completion strobe |
| ack_o | output | 3 | Acknowledge of the last transaction |
| rdata_o | output | DATA_W | Word from the last OK read |
| perr_o | output | 1 | Read parity mismatch on the last transaction |
| swclk_o | output | 1 | Serial clock |
| swdio_o | output | 1 | Serial data driven toward the target |
| swdio_oe_o | output | 1 | Output enable for the data pad |
| swdio_i | input | 1 | Serial data from the pad |

## Verification
The bound checker watches the timing on every cycle. It checks the serial half period against the divider setting and confirms that driven data and its enable hold steady while the clock is high. It also checks that the clock rests low with the line driven when idle, that completion is a single pulse ending the busy window, and that a parity error is only ever reported alongside an OK acknowledge. The bench's scenarios cover the frame content, using a behavioural target on the pins. That covers the header bits and their parity, the enable pattern per bit, the write data and its parity, the read word and the error flag, the shortened faulted frame, and the refusal of requests made while busy.

// File: rtl/swd_host_pkg.sv
package swd_host_pkg;

   localparam int          ACK_W  = 3;
   localparam int          HDR_W  = 8;
   localparam logic [2:0]  ACK_OK = 3'b001;

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_HDR,
      PH_TRN1,
      PH_ACK,
      PH_RDAT,
      PH_RPAR,
      PH_TRN2,
      PH_WDAT,
      PH_WPAR
   } phase_e;

endpackage

// File: rtl/swd_clk_div.sv
module swd_clk_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             swclk_o,
   output logic             rise_o,
   output logic             fall_o
);

   logic [DIV_W-1:0] cnt_q;
   logic             lvl_q;
   logic             wrap;

   assign wrap    = (cnt_q == div_i);
   assign rise_o  = run_i && wrap && !lvl_q;
   assign fall_o  = run_i && wrap && lvl_q;
   assign swclk_o = lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lvl_q <= 1'b0;
      end else if (!run_i) begin
         cnt_q <= '0;
         lvl_q <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         lvl_q <= !lvl_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/swd_hdr_build.sv
module swd_hdr_build
   import swd_host_pkg::*;
(
   input  logic             ap_i,
   input  logic             rd_i,
   input  logic [1:0]       addr_i,
   output logic [HDR_W-1:0] hdr_o
);

   localparam int NFLD = 4;

   logic [NFLD-1:0] fld;
   logic [NFLD:0]   acc;

   assign fld    = {addr_i[1], addr_i[0], rd_i, ap_i};
   assign acc[0] = 1'b0;

   for (genvar i = 0; i < NFLD; i++) begin : g_par
      assign acc[i+1] = acc[i] ^ fld[i];
   end

   // park, stop, parity, address, direction, port, start
   assign hdr_o = {1'b1, 1'b0, acc[NFLD], fld, 1'b1};

endmodule

// File: rtl/swd_data_sr.sv
module swd_data_sr #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] load_val_i,
   input  logic              shin_i,
   input  logic              shout_i,
   input  logic              din_i,
   output logic              lsb_o,
   output logic [DATA_W-1:0] word_o,
   output logic              wpar_o,
   output logic              xpar_o
);

   logic [DATA_W-1:0] sr_q;
   logic              wpar_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '0;
         wpar_q <= 1'b0;
      end else if (load_i) begin
         sr_q   <= load_val_i;
         wpar_q <= ^load_val_i;
      end else if (shin_i) begin
         sr_q   <= {din_i, sr_q[DATA_W-1:1]};
      end else if (shout_i) begin
         sr_q   <= {1'b0, sr_q[DATA_W-1:1]};
      end
   end

   assign lsb_o  = sr_q[0];
   assign word_o = sr_q;
   assign wpar_o = wpar_q;
   assign xpar_o = ^sr_q;

endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine
   import swd_host_pkg::*;
#(
   parameter int DIV_W  = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  clk_div_i,
   input  logic              req_valid_i,
   input  logic              req_ap_i,
   input  logic              req_read_i,
   input  logic [1:0]        req_addr_i,
   input  logic [DATA_W-1:0] req_wdata_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [ACK_W-1:0]  ack_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              perr_o,
   output logic              swclk_o,
   output logic              swdio_o,
   output logic              swdio_oe_o,
   input  logic              swdio_i
);

   localparam int CNT_W = $clog2(DATA_W);

   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end
   if (DATA_W < HDR_W) begin : g_bad_data
      $error("DATA_W must be at least the header width");
   end

   phase_e            ph;
   logic [CNT_W-1:0]  bitcnt;
   logic [HDR_W-1:0]  hdr_q;
   logic [HDR_W-1:0]  hdr_w;
   logic              rd_q;
   logic [ACK_W-1:0]  ack_q;
   logic              rpar_q;
   logic              rise;
   logic              fall;
   logic              accept;
   logic              ack_ok;
   logic              sr_lsb;
   logic              sr_wpar;
   logic              sr_xpar;
   logic [DATA_W-1:0] sr_word;
   logic              last_data;

   assign busy_o    = (ph != PH_IDLE);
   assign accept    = req_valid_i && !busy_o;
   assign ack_ok    = (ack_q == ACK_OK);
   assign last_data = (bitcnt == CNT_W'(DATA_W-1));

   swd_clk_div #(.DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (busy_o),
      .div_i   (clk_div_i),
      .swclk_o (swclk_o),
      .rise_o  (rise),
      .fall_o  (fall)
   );

   swd_hdr_build u_hdr (
      .ap_i   (req_ap_i),
      .rd_i   (req_read_i),
      .addr_i (req_addr_i),
      .hdr_o  (hdr_w)
   );

   swd_data_sr #(.DATA_W(DATA_W)) u_sr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (accept),
      .load_val_i (req_wdata_i),
      .shin_i     (rise && (ph == PH_RDAT)),
      .shout_i    (fall && (ph == PH_WDAT)),
      .din_i      (swdio_i),
      .lsb_o      (sr_lsb),
      .word_o     (sr_word),
      .wpar_o     (sr_wpar),
      .xpar_o     (sr_xpar)
   );

   always_comb begin
      unique case (ph)
         PH_HDR:  swdio_o = hdr_q[bitcnt[2:0]];
         PH_WDAT: swdio_o = sr_lsb;
         PH_WPAR: swdio_o = sr_wpar;
         default: swdio_o = 1'b0;
      endcase
   end

   always_comb begin
      unique case (ph)
         PH_IDLE, PH_HDR, PH_WDAT, PH_WPAR: swdio_oe_o = 1'b1;
         default:                           swdio_oe_o = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph      <= PH_IDLE;
         bitcnt  <= '0;
         hdr_q   <= '0;
         rd_q    <= 1'b0;
         ack_q   <= '0;
         rpar_q  <= 1'b0;
         done_o  <= 1'b0;
         ack_o   <= '0;
         rdata_o <= '0;
         perr_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (accept) begin
            ph     <= PH_HDR;
            bitcnt <= '0;
            hdr_q  <= hdr_w;
            rd_q   <= req_read_i;
            ack_q  <= '0;
         end else if (rise) begin
            if (ph == PH_ACK) ack_q[bitcnt[1:0]] <= swdio_i;
            if (ph == PH_RPAR) rpar_q <= swdio_i;
         end else if (fall) begin
            bitcnt <= bitcnt + 1'b1;
            unique case (ph)
               PH_HDR: begin
                  if (bitcnt == CNT_W'(HDR_W-1)) begin
                     ph     <= PH_TRN1;
                     bitcnt <= '0;
                  end
               end
               PH_TRN1: begin
                  ph     <= PH_ACK;
                  bitcnt <= '0;
               end
               PH_ACK: begin
                  if (bitcnt == CNT_W'(ACK_W-1)) begin
                     ph     <= (ack_ok && rd_q) ? PH_RDAT : PH_TRN2;
                     bitcnt <= '0;
                  end
               end
               PH_RDAT: begin
                  if (last_data) begin
                     ph     <= PH_RPAR;
                     bitcnt <= '0;
                  end
               end
               PH_RPAR: ph <= PH_TRN2;
               PH_TRN2: begin
                  if (!rd_q && ack_ok) begin
                     ph     <= PH_WDAT;
                     bitcnt <= '0;
                  end else begin
                     ph     <= PH_IDLE;
                     done_o <= 1'b1;
                     ack_o  <= ack_q;
                     perr_o <= rd_q && ack_ok && (rpar_q != sr_xpar);
                     if (rd_q && ack_ok) rdata_o <= sr_word;
                  end
               end
               PH_WDAT: begin
                  if (last_data) begin
                     ph     <= PH_WPAR;
                     bitcnt <= '0;
                  end
               end
               PH_WPAR: begin
                  ph     <= PH_IDLE;
                  done_o <= 1'b1;
                  ack_o  <= ack_q;
                  perr_o <= 1'b0;
               end
               default: ph <= PH_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/swd_host_chk.sv
module swd_host_chk #(
   parameter int DIV_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DIV_W-1:0] div_i,
   input logic             busy_i,
   input logic             done_i,
   input logic             swclk_i,
   input logic             dat_i,
   input logic             oe_i,
   input logic [2:0]       ack_i,
   input logic             perr_i
);

   logic             prev_clk;
   logic             prev_busy;
   logic [DIV_W:0]   lvl_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_clk  <= 1'b0;
         prev_busy <= 1'b0;
         lvl_cnt   <= '0;
      end else begin
         prev_clk  <= swclk_i;
         prev_busy <= busy_i;
         if (!busy_i) lvl_cnt <= '0;
         else if ((swclk_i != prev_clk) || !prev_busy) lvl_cnt <= 1;
         else lvl_cnt <= lvl_cnt + 1'b1;
      end
   end

   a_r9_half_period: assert property (@(posedge clk) disable iff (!rst_n)
      ((swclk_i != prev_clk) && prev_busy) |-> (lvl_cnt == ({1'b0, div_i} + 1'b1)));

   a_r9_stable_while_high: assert property (@(posedge clk) disable iff (!rst_n)
      (swclk_i && prev_clk) |-> ($stable(dat_i) && $stable(oe_i)));

   a_r11_idle_rest: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_i |-> (!swclk_i && oe_i));

   a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |-> (!busy_i && prev_busy));

   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> !done_i);

   a_r6_perr_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && perr_i) |-> (ack_i == 3'b001));

endmodule

bind swd_host_engine swd_host_chk #(.DIV_W(DIV_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .div_i   (clk_div_i),
   .busy_i  (busy_o),
   .done_i  (done_o),
   .swclk_i (swclk_o),
   .dat_i   (swdio_o),
   .oe_i    (swdio_oe_o),
   .ack_i   (ack_o),
   .perr_i  (perr_o)
);

// File: tb/swd_host_engine_tb.sv
module swd_host_engine_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DIV_W      = 8;
   localparam int DATA_W     = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [DIV_W-1:0]  clk_div = 8'd1;
   logic              req_valid = 1'b0;
   logic              req_ap = 1'b0;
   logic              req_read = 1'b0;
   logic [1:0]        req_addr = 2'd0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic              busy, done, perr, swclk, swdio_o, swdio_oe;
   logic              swdio_i = 1'b1;
   logic [2:0]        ack;
   logic [DATA_W-1:0] rdata;

   int checks = 0;
   int fails  = 0;

   // behavioural target
   int          k = 0;
   logic        obs_d  [0:63];
   logic        obs_oe [0:63];
   longint      rise_t [0:63];
   logic [2:0]  t_ack = 3'b001;
   logic        t_rd = 1'b0;
   logic [31:0] t_rdata = '0;
   logic        t_flip = 1'b0;
   logic [31:0] last_rdata = '0;

   swd_host_engine #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .clk_div_i   (clk_div),
      .req_valid_i (req_valid),
      .req_ap_i    (req_ap),
      .req_read_i  (req_read),
      .req_addr_i  (req_addr),
      .req_wdata_i (req_wdata),
      .busy_o      (busy),
      .done_o      (done),
      .ack_o       (ack),
      .rdata_o     (rdata),
      .perr_o      (perr),
      .swclk_o     (swclk),
      .swdio_o     (swdio_o),
      .swdio_oe_o  (swdio_oe),
      .swdio_i     (swdio_i)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic tgt_bit(input int j);
      if (j >= 9 && j <= 11) return t_ack[j-9];
      if (t_rd && t_ack == 3'b001) begin
         if (j >= 12 && j <= 43) return t_rdata[j-12];
         if (j == 44) return (^t_rdata) ^ t_flip;
      end
      return 1'b1;
   endfunction

   initial begin
      forever begin
         @(posedge swclk);
         if (k < 64) begin
            obs_d[k]  = swdio_o;
            obs_oe[k] = swdio_oe;
            rise_t[k] = longint'($time);
         end
         k = k + 1;
         swdio_i = tgt_bit(k);
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_hdr(input logic ap, input logic rd, input logic [1:0] a);
      logic p;
      p = ap ^ rd ^ a[0] ^ a[1];
      return {1'b1, 1'b0, p, a[1], a[0], rd, ap, 1'b1};
   endfunction

   task automatic wait_done(output bit ok);
      int n;
      n = 0;
      while (!done && n < 20000) begin
         @(negedge clk);
         n++;
      end
      ok = done;
   endtask

   // one complete transfer against the target model, with all frame checks
   task automatic xfer(input string nm, input logic ap, input logic rd, input logic [1:0] a,
                       input logic [31:0] wd, input logic [2:0] tack, input logic [31:0] trd,
                       input logic flip, input bit poke_busy);
      bit ok;
      logic [7:0]  hdr;
      logic [45:0] oe_v, oe_e;
      logic [31:0] wbits;
      int nbits;
      t_ack = tack; t_rd = rd; t_rdata = trd; t_flip = flip;
      @(negedge clk);
      k = 0; swdio_i = 1'b1;
      req_ap = ap; req_read = rd; req_addr = a; req_wdata = wd; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk({nm, " R10 busy after accept"}, 64'(busy), 64'd1);
      if (poke_busy) begin
         repeat (20) @(negedge clk);
         req_ap = ~ap; req_read = ~rd; req_addr = ~a; req_valid = 1'b1;
         @(negedge clk);
         req_valid = 1'b0;
      end
      wait_done(ok);
      chk({nm, " R10 completes"}, 64'(ok), 64'd1);
      if (!ok) return;
      chk({nm, " R10 busy low at done"}, 64'(busy), 64'd0);
      nbits = (tack == 3'b001) ? 46 : 13;
      chk({nm, " R8 serial period count"}, 64'(k), 64'(nbits));
      chk({nm, " R4 ack"}, 64'(ack), 64'(tack));
      for (int i = 0; i < 8; i++) hdr[i] = obs_d[i];
      chk({nm, " R1 R2 header"}, 64'(hdr), 64'(exp_hdr(ap, rd, a)));
      oe_v = '0; oe_e = '0;
      for (int i = 0; i < 46; i++) begin
         if (i < nbits) begin
            oe_v[i] = obs_oe[i];
            oe_e[i] = (i < 8) || (!rd && tack == 3'b001 && i >= 13);
         end
      end
      chk({nm, " R3 enable pattern"}, 64'(oe_v), 64'(oe_e));
      if (rd && tack == 3'b001) begin
         last_rdata = trd;
         chk({nm, " R5 read word"}, 64'(rdata), 64'(trd));
         chk({nm, " R6 parity flag"}, 64'(perr), 64'(flip));
      end else begin
         chk({nm, " R8 rdata kept"}, 64'(rdata), 64'(last_rdata));
         chk({nm, " R6 no flag"}, 64'(perr), 64'd0);
      end
      if (!rd && tack == 3'b001) begin
         for (int i = 0; i < 32; i++) wbits[i] = obs_d[13+i];
         chk({nm, " R7 write bits"}, 64'(wbits), 64'(wd));
         chk({nm, " R7 write parity"}, 64'(obs_d[45]), 64'(^wd));
      end
      @(negedge clk);
      chk({nm, " R10 done single"}, 64'(done), 64'd0);
      if (poke_busy) begin
         repeat (10) @(negedge clk);
         chk({nm, " R10 ignored request no restart"}, 64'(busy), 64'd0);
         chk({nm, " R10 ignored request no edges"}, 64'(k), 64'(nbits));
      end
   endtask

   task automatic t_reset;
      chk("R11 busy", 64'(busy), 64'd0);
      chk("R11 done", 64'(done), 64'd0);
      chk("R11 swclk", 64'(swclk), 64'd0);
      chk("R11 oe", 64'(swdio_oe), 64'd1);
   endtask

   task automatic t_dp_read;
      clk_div = 8'd1;
      xfer("dp_read", 1'b0, 1'b1, 2'd0, 32'h0, 3'b001, 32'h2BA0_1477, 1'b0, 1'b0);
   endtask

   task automatic t_ap_read_bad_parity;
      clk_div = 8'd1;
      xfer("ap_read_perr", 1'b1, 1'b1, 2'd3, 32'h0, 3'b001, 32'hFFFF_FFFF, 1'b1, 1'b0);
   endtask

   task automatic t_dp_write;
      clk_div = 8'd0;
      xfer("dp_write", 1'b0, 1'b0, 2'd1, 32'hF000_0001, 3'b001, 32'h0, 1'b0, 1'b0);
   endtask

   task automatic t_ap_write_odd;
      clk_div = 8'd0;
      xfer("ap_write_odd", 1'b1, 1'b0, 2'd2, 32'h8000_0A01, 3'b001, 32'h0, 1'b0, 1'b0);
   endtask

   task automatic t_read_wait;
      clk_div = 8'd1;
      xfer("read_wait", 1'b1, 1'b1, 2'd3, 32'h0, 3'b010, 32'h1234_5678, 1'b0, 1'b0);
   endtask

   task automatic t_write_fault;
      clk_div = 8'd1;
      xfer("write_fault", 1'b0, 1'b0, 2'd2, 32'hDEAD_BEEF, 3'b100, 32'h0, 1'b0, 1'b0);
   endtask

   task automatic t_half_period;
      clk_div = 8'd3;
      xfer("div3_read", 1'b0, 1'b1, 2'd1, 32'h0, 3'b001, 32'h0F0F_5A5A, 1'b0, 1'b0);
      chk("R9 serial period at div 3", 64'(rise_t[1] - rise_t[0]), 64'(2 * 4 * CLK_PERIOD));
   endtask

   task automatic t_busy_ignored;
      clk_div = 8'd1;
      xfer("busy_poke", 1'b1, 1'b0, 2'd1, 32'h0000_0003, 3'b001, 32'h0, 1'b0, 1'b1);
   endtask

   task automatic finish_run;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_dp_read();
      t_ap_read_bad_parity();
      t_dp_write();
      t_ap_write_odd();
      t_read_wait();
      t_write_fault();
      t_half_period();
      t_busy_ignored();
      finish_run();
   end

endmodule